// File: doc/BRIEF.md
# I2C Slave Byte Engine with Address Recognition

This block is the receive datapath and control core of a multi-master I2C port. A CPU side writes an 8-bit control register, two own-address bytes and a data shift register through single-cycle write strobes. The bus side delivers raw samples of two candidate pins per line and single-cycle START, STOP and arbitration-loss strobes from an external bus conditioner. Serial data is captured on rising SCL edges into the shift register. When the programmed number of bits has arrived, a one-cycle interrupt request is raised.

After a START, the engine examines the first received byte, and in 10-bit mode the second byte as well. It compares them against the own address and flags a match or a general call. In free data format it performs no address recognition. Two routing bits choose which of the two physical pins carries SCL and which carries SDA. They steer both the sampled inputs and the open-drain pull requests of the surrounding logic.

Top module: `i2c_byte_engine`

## Requirements
- R1: Control bits 2:0 set the length of the next transfer: values 1..7 mean that many bits, 0 means 8. Bits enter the shift register on rising edges of the selected SCL, most significant first (shift left, new bit into bit 0). `irq` is high for exactly one cycle after the final bit of the transfer.
- R2: A START strobe clears control bits 2:0 and restarts the bit count, so the next byte is 8 bits. The other control bits are kept. When a CPU control write lands in the same cycle, the written value is taken, but with bits 2:0 cleared.
- R3: While control bit 3 (enable) is 0, the following hold. `st_idle` is 1, `st_busy` is 0 and `st_arblost` is 0. All pull outputs are 0 (released, high-impedance). No bits are shifted. While enabled, the arbitration-loss strobe sets `st_arblost`.
- R4: A CPU write to the data shift register is ignored while disabled. While enabled, the write loads the register, sets `st_idle` to 1 and restarts the bit count.
- R5: With control bit 4 = 0 (addressing) and bit 5 = 0 (7-bit), `st_match` is set after the first byte following START when bits 7:1 of that byte equal bits 7:1 of the high own-address byte. Bit 0 is ignored.
- R6: In addressing format, a first byte of 0x00 sets `st_gcall`.
- R7: With bit 5 = 1 (10-bit), `st_match` is set only after the second byte, and only if the first byte equals the whole high own-address byte and the second byte equals the whole low own-address byte.
- R8: With control bit 4 = 1 (free data format), neither `st_match` nor `st_gcall` is ever set.
- R9: START sets `st_busy` and STOP clears it. Both START and STOP clear `st_match` and `st_gcall`.
- R10: Control bit 6 selects the SCL pin and bit 7 the SDA pin (0 = pin 0, 1 = pin 1). The unselected pin's input is ignored and its pull output stays 0.
- R11: Completing a transfer clears `st_idle` to 0. It stays 0 until the next shift-register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wdata | input | 8 | CPU write data |
| wr_ctrl | input | 1 | Write strobe for the control register |
| wr_own_hi | input | 1 | Write strobe for the high own-address byte |
| wr_own_lo | input | 1 | Write strobe for the low own-address byte |
| wr_shift | input | 1 | Write strobe for the data shift register |
| scl_pin_i | input | 2 | Sampled SCL level of each candidate pin |
| sda_pin_i | input | 2 | Sampled SDA level of each candidate pin |
| start_det | input | 1 | START condition strobe |
| stop_det | input | 1 | STOP condition strobe |
| arb_lost_evt | input | 1 | Arbitration-loss strobe |
| scl_pull_req | input | 1 | Request to pull SCL low |
| sda_pull_req | input | 1 | Request to pull SDA low |
| ctrl_o | output | 8 | Current control register value |
| shift_o | output | 8 | Current shift register value |
| irq | output | 1 | Transfer-complete interrupt pulse |
| st_idle | output | 1 | 1 = no completed transfer awaiting service |
| st_busy | output | 1 | Bus busy flag |
| st_arblost | output | 1 | Arbitration lost flag |
| st_match | output | 1 | Own address recognised |
| st_gcall | output | 1 | General call recognised |
| scl_pull_o | output | 2 | Per-pin SCL pull-low enable (0 = released) |
| sda_pull_o | output | 2 | Per-pin SDA pull-low enable (0 = released) |

## Verification
The case that needs care is a START strobe arriving in the same cycle as a CPU control-register write. Both update the control register, and the result must be the written value with the bit-count field cleared. The bench provokes this by raising `wr_ctrl` and `start_det` together on one clock, with a nonzero count field in the written data. It then compares `ctrl_o` with the written value masked in bits 2:0. The same collision is judged with the count field both nonzero and already zero. A second pair is also exercised: a shift-register write while disabled, right before enabling, must not leave its value behind.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

   // control register image, bit 7 down to bit 0
   typedef struct packed {
      logic       sda_sel;   // 7
      logic       scl_sel;   // 6
      logic       ten_bit;   // 5
      logic       free_fmt;  // 4
      logic       en;        // 3
      logic [2:0] bcnt;      // 2:0
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/i2c_eng_route.sv
module i2c_eng_route #(
   parameter int NPIN = 2,
   localparam int SW  = (NPIN > 1) ? $clog2(NPIN) : 1
) (
   input  logic [NPIN-1:0] scl_pins,
   input  logic [NPIN-1:0] sda_pins,
   input  logic [SW-1:0]   scl_sel,
   input  logic [SW-1:0]   sda_sel,
   input  logic            en,
   input  logic            scl_req,
   input  logic            sda_req,
   output logic            scl_in,
   output logic            sda_in,
   output logic [NPIN-1:0] scl_pull,
   output logic [NPIN-1:0] sda_pull
);

   assign scl_in = scl_pins[scl_sel];
   assign sda_in = sda_pins[sda_sel];

   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      assign scl_pull[p] = en && scl_req && (scl_sel == SW'(p));
      assign sda_pull[p] = en && sda_req && (sda_sel == SW'(p));
   end

endmodule

// File: rtl/i2c_eng_shift.sv
module i2c_eng_shift #(
   parameter int DW  = 8,
   localparam int BCW = $clog2(DW),
   localparam int CW  = BCW + 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           en,
   input  logic           start,
   input  logic           scl,
   input  logic           sda,
   input  logic [BCW-1:0] bcnt,
   input  logic           load,
   input  logic [DW-1:0]  ldata,
   output logic [DW-1:0]  data_q,
   output logic           done_q
);

   logic          scl_prev;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] target;
   logic          rise;

   assign target = (bcnt == '0) ? CW'(DW) : {1'b0, bcnt};
   assign rise   = scl && !scl_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         cnt_q    <= '0;
         data_q   <= '0;
         done_q   <= 1'b0;
      end else begin
         scl_prev <= scl;
         done_q   <= 1'b0;
         if (!en) begin
            cnt_q <= '0;
         end else if (start) begin
            cnt_q <= '0;
         end else if (load) begin
            data_q <= ldata;
            cnt_q  <= '0;
         end else if (rise) begin
            data_q <= {data_q[DW-2:0], sda};
            if (cnt_q + 1'b1 == target) begin
               cnt_q  <= '0;
               done_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/i2c_eng_match.sv
module i2c_eng_match #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          start,
   input  logic          stop,
   input  logic          byte_done,
   input  logic [DW-1:0] rx_byte,
   input  logic          free_fmt,
   input  logic          ten_bit,
   input  logic [DW-1:0] own_hi,
   input  logic [DW-1:0] own_lo,
   output logic          match_q,
   output logic          gcall_q
);

   typedef enum logic [1:0] {PH_FIRST, PH_SECOND, PH_DATA} phase_t;

   phase_t phase_q;
   logic   hi_ok_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_FIRST;
         hi_ok_q <= 1'b0;
         match_q <= 1'b0;
         gcall_q <= 1'b0;
      end else if (!en || start || stop) begin
         phase_q <= PH_FIRST;
         hi_ok_q <= 1'b0;
         match_q <= 1'b0;
         gcall_q <= 1'b0;
      end else if (byte_done && !free_fmt) begin
         case (phase_q)
            PH_FIRST: begin
               phase_q <= PH_SECOND;
               if (rx_byte == '0)
                  gcall_q <= 1'b1;
               if (ten_bit)
                  hi_ok_q <= (rx_byte == own_hi);
               else if (rx_byte[DW-1:1] == own_hi[DW-1:1])
                  match_q <= 1'b1;
            end
            PH_SECOND: begin
               phase_q <= PH_DATA;
               if (ten_bit && hi_ok_q && rx_byte == own_lo)
                  match_q <= 1'b1;
            end
            default: phase_q <= PH_DATA;
         endcase
      end
   end

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
   import i2c_eng_pkg::*;
#(
   parameter int DW   = 8,
   parameter int NPIN = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [7:0]      cpu_wdata,
   input  logic            wr_ctrl,
   input  logic            wr_own_hi,
   input  logic            wr_own_lo,
   input  logic            wr_shift,
   input  logic [1:0]      scl_pin_i,
   input  logic [1:0]      sda_pin_i,
   input  logic            start_det,
   input  logic            stop_det,
   input  logic            arb_lost_evt,
   input  logic            scl_pull_req,
   input  logic            sda_pull_req,
   output logic [7:0]      ctrl_o,
   output logic [7:0]      shift_o,
   output logic            irq,
   output logic            st_idle,
   output logic            st_busy,
   output logic            st_arblost,
   output logic            st_match,
   output logic            st_gcall,
   output logic [1:0]      scl_pull_o,
   output logic [1:0]      sda_pull_o
);

   localparam int BCW = $clog2(DW);

   if (DW != 8) begin : g_bad_dw
      $error("i2c_byte_engine: DW must be 8 to fit the control layout");
   end
   if (NPIN != 2) begin : g_bad_npin
      $error("i2c_byte_engine: NPIN must be 2, one routing bit per line");
   end
   if (BCW != 3) begin : g_bad_bcw
      $error("i2c_byte_engine: bit-count field must be 3 bits");
   end

   ctrl_t         ctrl_q;
   logic [DW-1:0] own_hi_q, own_lo_q;
   logic          scl_in, sda_in;
   logic          done;
   logic          en;

   assign en = ctrl_q.en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         own_hi_q <= '0;
         own_lo_q <= '0;
      end else begin
         if (wr_ctrl)   ctrl_q   <= ctrl_t'(cpu_wdata);
         if (start_det) ctrl_q.bcnt <= '0;
         if (wr_own_hi) own_hi_q <= cpu_wdata;
         if (wr_own_lo) own_lo_q <= cpu_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_idle    <= 1'b1;
         st_busy    <= 1'b0;
         st_arblost <= 1'b0;
      end else if (!en) begin
         st_idle    <= 1'b1;
         st_busy    <= 1'b0;
         st_arblost <= 1'b0;
      end else begin
         if (start_det)     st_busy <= 1'b1;
         else if (stop_det) st_busy <= 1'b0;
         if (arb_lost_evt)  st_arblost <= 1'b1;
         if (wr_shift)      st_idle <= 1'b1;
         else if (done)     st_idle <= 1'b0;
      end
   end

   i2c_eng_route #(.NPIN(NPIN)) u_route (
      .scl_pins (scl_pin_i),
      .sda_pins (sda_pin_i),
      .scl_sel  (ctrl_q.scl_sel),
      .sda_sel  (ctrl_q.sda_sel),
      .en       (en),
      .scl_req  (scl_pull_req),
      .sda_req  (sda_pull_req),
      .scl_in   (scl_in),
      .sda_in   (sda_in),
      .scl_pull (scl_pull_o),
      .sda_pull (sda_pull_o)
   );

   i2c_eng_shift #(.DW(DW)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .start  (start_det),
      .scl    (scl_in),
      .sda    (sda_in),
      .bcnt   (ctrl_q.bcnt),
      .load   (wr_shift),
      .ldata  (cpu_wdata),
      .data_q (shift_o),
      .done_q (done)
   );

   i2c_eng_match #(.DW(DW)) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .start     (start_det),
      .stop      (stop_det),
      .byte_done (done),
      .rx_byte   (shift_o),
      .free_fmt  (ctrl_q.free_fmt),
      .ten_bit   (ctrl_q.ten_bit),
      .own_hi    (own_hi_q),
      .own_lo    (own_lo_q),
      .match_q   (st_match),
      .gcall_q   (st_gcall)
   );

   assign ctrl_o = ctrl_q;
   assign irq    = done;

endmodule

// File: rtl/i2c_byte_engine_chk.sv
module i2c_byte_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] ctrl_o,
   input logic [7:0] shift_o,
   input logic       start_det,
   input logic       stop_det,
   input logic       irq,
   input logic       st_idle,
   input logic       st_busy,
   input logic       st_arblost,
   input logic       st_match,
   input logic       st_gcall,
   input logic [1:0] scl_pull_o,
   input logic [1:0] sda_pull_o
);

   // R1
   irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R2
   start_clears_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> ctrl_o[2:0] == 3'b000);

   // R3
   disabled_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_o[3] |=> st_idle && !st_busy && !st_arblost);

   // R3
   disabled_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_o[3] |-> scl_pull_o == 2'b00 && sda_pull_o == 2'b00);

   // R4
   disabled_shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_o[3] |=> $stable(shift_o));

   // R8
   free_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_o[4] |=> !$rose(st_match) && !$rose(st_gcall));

   // R9
   stop_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !st_match && !st_gcall);

   // R10
   one_pin_pulled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(scl_pull_o) && $onehot0(sda_pull_o));

endmodule

bind i2c_byte_engine i2c_byte_engine_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctrl_o     (ctrl_o),
   .shift_o    (shift_o),
   .start_det  (start_det),
   .stop_det   (stop_det),
   .irq        (irq),
   .st_idle    (st_idle),
   .st_busy    (st_busy),
   .st_arblost (st_arblost),
   .st_match   (st_match),
   .st_gcall   (st_gcall),
   .scl_pull_o (scl_pull_o),
   .sda_pull_o (sda_pull_o)
);

// File: tb/test_i2c_byte_engine.sv
module test_i2c_byte_engine;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cpu_wdata = '0;
   logic       wr_ctrl = 0, wr_own_hi = 0, wr_own_lo = 0, wr_shift = 0;
   logic [1:0] scl_pin_i = 2'b11, sda_pin_i = 2'b11;
   logic       start_det = 0, stop_det = 0, arb_lost_evt = 0;
   logic       scl_pull_req = 0, sda_pull_req = 0;
   logic [7:0] ctrl_o, shift_o;
   logic       irq, st_idle, st_busy, st_arblost, st_match, st_gcall;
   logic [1:0] scl_pull_o, sda_pull_o;

   int errors = 0, checks = 0, irq_cnt = 0;
   bit done_run = 0;
   int cidx = 0, didx = 0;

   always #2 clk = ~clk;

   i2c_byte_engine i_i2c_byte_engine (
      .clk(clk), .rst_n(rst_n), .cpu_wdata(cpu_wdata), .wr_ctrl(wr_ctrl),
      .wr_own_hi(wr_own_hi), .wr_own_lo(wr_own_lo), .wr_shift(wr_shift),
      .scl_pin_i(scl_pin_i), .sda_pin_i(sda_pin_i), .start_det(start_det),
      .stop_det(stop_det), .arb_lost_evt(arb_lost_evt),
      .scl_pull_req(scl_pull_req), .sda_pull_req(sda_pull_req),
      .ctrl_o(ctrl_o), .shift_o(shift_o), .irq(irq), .st_idle(st_idle),
      .st_busy(st_busy), .st_arblost(st_arblost), .st_match(st_match),
      .st_gcall(st_gcall), .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o));

   always @(negedge clk) if (rst_n && irq) irq_cnt++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cpu_wr(input int kind, input logic [7:0] d);
      @(negedge clk);
      cpu_wdata = d;
      wr_ctrl   = (kind == 0);
      wr_own_hi = (kind == 1);
      wr_own_lo = (kind == 2);
      wr_shift  = (kind == 3);
      @(negedge clk);
      {wr_ctrl, wr_own_hi, wr_own_lo, wr_shift} = '0;
   endtask

   task automatic strobe(input int kind);
      @(negedge clk);
      start_det    = (kind == 0);
      stop_det     = (kind == 1);
      arb_lost_evt = (kind == 2);
      @(negedge clk);
      {start_det, stop_det, arb_lost_evt} = '0;
      @(negedge clk);
   endtask

   // selected SCL pin clocks the bit; unselected pin toggles in antiphase
   task automatic send_bit(input logic b);
      @(negedge clk);
      sda_pin_i[didx]     = b;
      sda_pin_i[1 - didx] = ~b;
      scl_pin_i[cidx]     = 1'b0;
      scl_pin_i[1 - cidx] = 1'b1;
      repeat (2) @(negedge clk);
      scl_pin_i[cidx]     = 1'b1;
      scl_pin_i[1 - cidx] = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_run) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R3 reset ctrl", ctrl_o, 8'h00);
      chk("R3 reset status", {st_idle, st_busy, st_arblost, st_match, st_gcall}, 5'b10000);
      chk("R3 reset shift", shift_o, 8'h00);

      // R4: shift write while disabled is ignored
      cpu_wr(3, 8'h3C);
      chk("R4 disabled write ignored", shift_o, 8'h00);
      scl_pull_req = 1; sda_pull_req = 1;
      @(negedge clk);
      chk("R3 disabled pulls released", {scl_pull_o, sda_pull_o}, 4'b0000);

      // enable, pin 0 for both lines
      cpu_wr(0, 8'h08);
      chk("R10 pins 0 pulled", {scl_pull_o, sda_pull_o}, 4'b0101);
      scl_pull_req = 0; sda_pull_req = 0;
      cpu_wr(3, 8'hA5);
      chk("R4 enabled write loads", shift_o, 8'hA5);

      // R1 / R11: sweep every bit-count value
      for (int n = 1; n <= 8; n++) begin
         logic [7:0] pat, expv;
         pat  = (8'h6B ^ 8'(n)) & 8'((1 << n) - 1);
         expv = 8'(({8'h00, 8'hA5} << n) | {8'h00, pat});
         cpu_wr(0, 8'h08 | 8'(n % 8));
         cpu_wr(3, 8'hA5);
         chk("R4 write sets idle", st_idle, 1'b1);
         irq_cnt = 0;
         for (int i = n - 1; i >= 1; i--) send_bit(pat[i]);
         chk("R1 no irq before last bit", irq_cnt, 0);
         send_bit(pat[0]);
         @(negedge clk);
         chk("R1 one irq after count", irq_cnt, 1);
         chk("R1 shifted value msb first", shift_o, expv);
         chk("R11 idle cleared on completion", st_idle, 1'b0);
      end

      // R2: START clears count field, keeps others
      cpu_wr(0, 8'h0B);
      strobe(0);
      chk("R2 start clears count", ctrl_o, 8'h08);
      chk("R9 start sets busy", st_busy, 1'b1);
      strobe(1);
      chk("R9 stop clears busy", st_busy, 1'b0);

      // R2: START and control write in the same cycle
      @(negedge clk);
      cpu_wdata = 8'h1E; wr_ctrl = 1; start_det = 1;
      @(negedge clk);
      wr_ctrl = 0; start_det = 0;
      chk("R2 start with ctrl write", ctrl_o, 8'h18);
      @(negedge clk);
      cpu_wdata = 8'h08; wr_ctrl = 1; start_det = 1;
      @(negedge clk);
      wr_ctrl = 0; start_det = 0;
      chk("R2 start with ctrl write zero field", ctrl_o, 8'h08);
      strobe(1);

      // R5 / R6: exhaustive first byte against 7-bit own address 0x5C
      cpu_wr(1, 8'h5C);
      cpu_wr(0, 8'h08);
      for (int b = 0; b < 256; b++) begin
         strobe(0);
         send_byte(8'(b));
         chk("R5 7-bit match", st_match, (b >> 1) == 8'h2E);
         chk("R6 general call", st_gcall, b == 0);
         strobe(1);
      end
      strobe(0);
      send_byte(8'h5D);
      chk("R5 match with bit0 set", st_match, 1'b1);
      strobe(1);
      chk("R9 stop clears match", st_match, 1'b0);
      strobe(0);
      send_byte(8'h00);
      strobe(0);
      chk("R9 start clears gcall", st_gcall, 1'b0);
      strobe(1);

      // R7: 10-bit matching
      cpu_wr(1, 8'hF2);
      cpu_wr(2, 8'h3B);
      cpu_wr(0, 8'h28);
      strobe(0);
      send_byte(8'hF2);
      chk("R7 no match after first byte", st_match, 1'b0);
      send_byte(8'h3B);
      chk("R7 match after both bytes", st_match, 1'b1);
      strobe(1);
      strobe(0);
      send_byte(8'hF2); send_byte(8'h3C);
      chk("R7 low byte mismatch", st_match, 1'b0);
      strobe(1);
      strobe(0);
      send_byte(8'hF3); send_byte(8'h3B);
      chk("R7 high byte bit0 mismatch", st_match, 1'b0);
      strobe(1);

      // R8: free data format
      cpu_wr(1, 8'h5C);
      cpu_wr(0, 8'h18);
      strobe(0);
      send_byte(8'h5C);
      chk("R8 free format no match", st_match, 1'b0);
      strobe(1);
      strobe(0);
      send_byte(8'h00);
      chk("R8 free format no gcall", st_gcall, 1'b0);
      strobe(1);

      // R10: route both lines to pin 1
      cpu_wr(0, 8'hC8);
      cidx = 1; didx = 1;
      scl_pin_i = 2'b10; sda_pin_i = 2'b10;
      cpu_wr(3, 8'h00);
      irq_cnt = 0;
      send_byte(8'hC3);
      chk("R10 data from pin 1", shift_o, 8'hC3);
      chk("R10 clock from pin 1", irq_cnt, 1);
      scl_pull_req = 1; sda_pull_req = 1;
      @(negedge clk);
      chk("R10 pin 1 pulled", {scl_pull_o, sda_pull_o}, 4'b1010);
      cpu_wr(0, 8'h48);
      chk("R10 split routing", {scl_pull_o, sda_pull_o}, 4'b1001);

      // R3: arbitration loss then disable
      strobe(2);
      chk("R3 arb lost set when enabled", st_arblost, 1'b1);
      strobe(0);
      cpu_wr(3, 8'h77);
      cpu_wr(0, 8'h40);
      @(negedge clk);
      chk("R3 disable forces status", {st_idle, st_busy, st_arblost}, 3'b100);
      chk("R3 disable releases pulls", {scl_pull_o, sda_pull_o}, 4'b0000);
      irq_cnt = 0;
      send_byte(8'h12);
      chk("R3 no shifting while disabled", shift_o, 8'h77);
      chk("R3 no irq while disabled", irq_cnt, 0);
      cpu_wr(3, 8'hEE);
      chk("R4 write ignored after disable", shift_o, 8'h77);

      done_run = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule